// File: doc/BRIEF.md
# Lane Rate Reconfiguration Sequencer

This block moves one serial transceiver lane from the rate profile it runs now to a target profile, with no software involved. A one-cycle start request captures the target: a profile number, a group count, a lanes-per-group count, a rate code and a FEC mode. The sequencer then holds the lane's transmit and receive resets and waits until the lane acknowledges both. It programs the reconfiguration engine over a single-transaction memory-mapped master port. If the grouping settings differ from those last applied, it rewrites the three grouping words. It then reads the engine's status word until the new configuration is reported applied. Last, it releases the resets and waits for the lane to report ready.

Each of the three waits has a cycle limit taken from an input. If a wait runs past its limit, the sequencer parks in an error state. There it keeps both resets asserted and raises an error flag until the next start request. The sequencer remembers the profile and grouping of the last successful switch. It starts from parameter defaults.

Top module: `lane_reconf_seq`

## Requirements
- R1: A start request sampled while idle or in error is accepted. From the next cycle, busy, tx_rst and rx_rst are high, and done and err are low.
- R2: No bus transaction takes place before the cycle in which tx_rst_ack and rx_rst_ack are both seen high.
- R3: After the reset handshake, three writes are issued in this order. First, CTRL_BASE+0x0 with the current profile number. Second, CTRL_BASE+0x4 with the target profile number. Third, CTRL_BASE+0x8 with the value 1. The default CTRL_BASE is 0x00100.
- R4: The three grouping words 0x820, 0x824 and 0x828 are written in that order, right after the third control write. This happens only when the target's groups, lanes, rate or FEC differ from the last applied values. The defaults are 1, 1, 1 and 0. Otherwise no grouping word is written.
- R5: Word 0x820 holds the group count in bits [13:9], the lanes per group in [8:4] and the rate code in [3:0], with bits [31:14] zero. Rate code 1 means 25.78125 Gb/s and 2 means 53.125 Gb/s. Word 0x824 holds the FEC mode in its low bits: 0 is off and 2 is RS(544,514). Word 0x828 holds the rate code in [3:0].
- R6: After the writes, the status word at CTRL_BASE+0xC is read repeatedly, one read at a time, until a read returns bit 0 set. Both resets stay high throughout.
- R7: After the applied bit is seen, both resets drop. done rises only after tx_ready and rx_ready have both been seen high. busy falls in the same cycle that done rises.
- R8: If a wait lasts wait_limit cycles without its condition, the sequencer enters error. The three waits are for the reset acknowledges, for the applied bit and for lane ready. In error, err is high, busy is low and both resets are held high until the next accepted start.
- R9: A start request while busy is ignored. The run in progress keeps its captured target.
- R10: The master raises m_valid with a stable m_write, m_addr and m_wdata, and holds them until the cycle in which m_ready is high. A read finishes when m_rvalid returns the data.
- R11: After reset, tx_rst, rx_rst, busy, done, err and m_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start a profile switch |
| tgt_profile | input | PW | Target profile number |
| tgt_groups | input | 5 | Target group count |
| tgt_lanes | input | 5 | Target lanes per group |
| tgt_rate | input | 4 | Target rate code |
| tgt_fec | input | 2 | Target FEC mode |
| wait_limit | input | TW | Cycle limit for each wait |
| tx_rst | output | 1 | Lane transmit reset |
| rx_rst | output | 1 | Lane receive reset |
| tx_rst_ack | input | 1 | Transmit reset acknowledged |
| rx_rst_ack | input | 1 | Receive reset acknowledged |
| tx_ready | input | 1 | Lane transmit ready |
| rx_ready | input | 1 | Lane receive ready |
| m_valid | output | 1 | Bus request valid |
| m_write | output | 1 | Bus request is a write |
| m_addr | output | 20 | Bus word address |
| m_wdata | output | 32 | Bus write data |
| m_ready | input | 1 | Bus request accepted |
| m_rvalid | input | 1 | Read data valid |
| m_rdata | input | 32 | Read data |
| busy | output | 1 | Switch in progress |
| done | output | 1 | Last switch succeeded |
| err | output | 1 | Last switch timed out |

## Verification
The start request is sampled at one clock edge. busy and both resets are checked at the following falling edge, one register after that start edge. The timeout is checked cycle-exactly: with the acknowledges held low, err must still be low wait_limit-1 cycles after acceptance and high one cycle later. Bus ordering is checked by having the bench's engine model log every handshake with its cycle number. The log is compared against an expected sequence that the bench builds from its own record of the last applied settings. Bus latency, acknowledge delay and poll count are swept over a full sweep of the grouping fields. All outputs are sampled on the falling edge.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] GRP_WORD0 = 20'h00820;
    localparam logic [ADDR_W-1:0] GRP_WORD1 = 20'h00824;
    localparam logic [ADDR_W-1:0] GRP_WORD2 = 20'h00828;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_ACK,
        S_DIS,
        S_EN,
        S_GO,
        S_GW0,
        S_GW1,
        S_GW2,
        S_POLL,
        S_RDY,
        S_ERR
    } seq_state_e;

    typedef struct packed {
        logic [4:0] grp_cnt;
        logic [4:0] lanes_per_grp;
        logic [3:0] rate_code;
        logic [1:0] fec_sel;
    } lane_cfg_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_cmd_t;

    function automatic logic [DATA_W-1:0] pack_group_word(input lane_cfg_t c);
        return {{(DATA_W-14){1'b0}}, c.grp_cnt, c.lanes_per_grp, c.rate_code};
    endfunction

endpackage

// File: rtl/lrs_wait_timer.sv
module lrs_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != {TW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (({1'b0, cnt} + (TW+1)'(1)) >= {1'b0, limit});

endmodule

// File: rtl/lrs_mm_master.sv
module lrs_mm_master
    import lrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_go,
    input  bus_cmd_t          cmd_in,
    output logic              idle,
    output logic              cmd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              m_valid,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ready,
    input  logic              m_rvalid,
    input  logic [DATA_W-1:0] m_rdata
);
    typedef enum logic [1:0] {M_IDLE, M_REQ, M_RESP} mst_state_e;

    mst_state_e mst;
    bus_cmd_t   cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mst   <= M_IDLE;
            cmd_q <= '0;
        end else begin
            unique case (mst)
                M_IDLE: if (cmd_go) begin
                    cmd_q <= cmd_in;
                    mst   <= M_REQ;
                end
                M_REQ: if (m_ready) mst <= cmd_q.write ? M_IDLE : M_RESP;
                M_RESP: if (m_rvalid) mst <= M_IDLE;
                default: mst <= M_IDLE;
            endcase
        end
    end

    assign idle     = (mst == M_IDLE);
    assign m_valid  = (mst == M_REQ);
    assign m_write  = cmd_q.write;
    assign m_addr   = cmd_q.addr;
    assign m_wdata  = cmd_q.data;
    assign cmd_done = ((mst == M_REQ) && m_ready && cmd_q.write) ||
                      ((mst == M_RESP) && m_rvalid);
    assign rd_data  = m_rdata;

    // R10: request fields held until accepted
    assert_hold_request_R10: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

endmodule

// File: rtl/lane_reconf_seq.sv
module lane_reconf_seq
    import lrs_pkg::*;
#(
    parameter int                PW          = 4,
    parameter int                TW          = 16,
    parameter logic [ADDR_W-1:0] CTRL_BASE   = 20'h00100,
    parameter int                DEF_PROFILE = 0,
    parameter int                DEF_GROUPS  = 1,
    parameter int                DEF_LANES   = 1,
    parameter int                DEF_RATE    = 1,
    parameter int                DEF_FEC     = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [PW-1:0]     tgt_profile,
    input  logic [4:0]        tgt_groups,
    input  logic [4:0]        tgt_lanes,
    input  logic [3:0]        tgt_rate,
    input  logic [1:0]        tgt_fec,
    input  logic [TW-1:0]     wait_limit,
    output logic              tx_rst,
    output logic              rx_rst,
    input  logic              tx_rst_ack,
    input  logic              rx_rst_ack,
    input  logic              tx_ready,
    input  logic              rx_ready,
    output logic              m_valid,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ready,
    input  logic              m_rvalid,
    input  logic [DATA_W-1:0] m_rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [ADDR_W-1:0] CTRL_DIS  = CTRL_BASE;
    localparam logic [ADDR_W-1:0] CTRL_EN   = CTRL_BASE + 20'h4;
    localparam logic [ADDR_W-1:0] CTRL_GO   = CTRL_BASE + 20'h8;
    localparam logic [ADDR_W-1:0] CTRL_STAT = CTRL_BASE + 20'hC;
    localparam lane_cfg_t DEF_CFG = '{grp_cnt: 5'(DEF_GROUPS), lanes_per_grp: 5'(DEF_LANES),
                                      rate_code: 4'(DEF_RATE), fec_sel: 2'(DEF_FEC)};

    seq_state_e        st, st_n;
    lane_cfg_t         tgt_q, cur_cfg;
    logic [PW-1:0]     tgt_prof_q, cur_prof;
    logic              issued, done_q;
    bus_cmd_t          cmd;
    logic              cmd_go, cmd_done, mst_idle;
    logic [DATA_W-1:0] rd_data;
    logic              in_bus, step, applied, acks_ok, ready_ok, grp_change;
    logic              tmr_run, tmr_expire, accept;

    assign in_bus     = st inside {S_DIS, S_EN, S_GO, S_GW0, S_GW1, S_GW2, S_POLL};
    assign cmd_go     = in_bus && !issued && mst_idle;
    assign step       = in_bus && issued && cmd_done;
    assign applied    = (st == S_POLL) && step && rd_data[0];
    assign acks_ok    = tx_rst_ack && rx_rst_ack;
    assign ready_ok   = tx_ready && rx_ready;
    assign grp_change = (tgt_q != cur_cfg);
    assign accept     = (st == S_IDLE || st == S_ERR) && start_req;
    assign tmr_run    = ((st == S_RST_ACK) && !acks_ok) ||
                        ((st == S_POLL) && !applied) ||
                        ((st == S_RDY) && !ready_ok);

    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE, S_ERR: if (start_req) st_n = S_RST_ACK;
            S_RST_ACK: begin
                if (acks_ok)         st_n = S_DIS;
                else if (tmr_expire) st_n = S_ERR;
            end
            S_DIS: if (step) st_n = S_EN;
            S_EN:  if (step) st_n = S_GO;
            S_GO:  if (step) st_n = grp_change ? S_GW0 : S_POLL;
            S_GW0: if (step) st_n = S_GW1;
            S_GW1: if (step) st_n = S_GW2;
            S_GW2: if (step) st_n = S_POLL;
            S_POLL: begin
                if (applied)         st_n = S_RDY;
                else if (tmr_expire) st_n = S_ERR;
            end
            S_RDY: begin
                if (ready_ok)        st_n = S_IDLE;
                else if (tmr_expire) st_n = S_ERR;
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_comb begin
        cmd = '{write: 1'b1, addr: CTRL_DIS, data: '0};
        unique case (st)
            S_DIS: cmd.data = DATA_W'(cur_prof);
            S_EN: begin
                cmd.addr = CTRL_EN;
                cmd.data = DATA_W'(tgt_prof_q);
            end
            S_GO: begin
                cmd.addr = CTRL_GO;
                cmd.data = DATA_W'(1);
            end
            S_GW0: begin
                cmd.addr = GRP_WORD0;
                cmd.data = pack_group_word(tgt_q);
            end
            S_GW1: begin
                cmd.addr = GRP_WORD1;
                cmd.data = DATA_W'(tgt_q.fec_sel);
            end
            S_GW2: begin
                cmd.addr = GRP_WORD2;
                cmd.data = DATA_W'(tgt_q.rate_code);
            end
            S_POLL: begin
                cmd.write = 1'b0;
                cmd.addr  = CTRL_STAT;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            issued     <= 1'b0;
            done_q     <= 1'b0;
            tgt_q      <= DEF_CFG;
            tgt_prof_q <= PW'(DEF_PROFILE);
            cur_cfg    <= DEF_CFG;
            cur_prof   <= PW'(DEF_PROFILE);
        end else begin
            st <= st_n;
            if (st_n != st)  issued <= 1'b0;
            else if (cmd_go) issued <= 1'b1;
            else if (step)   issued <= 1'b0;
            if (accept) begin
                done_q     <= 1'b0;
                tgt_prof_q <= tgt_profile;
                tgt_q      <= '{grp_cnt: tgt_groups, lanes_per_grp: tgt_lanes,
                                rate_code: tgt_rate, fec_sel: tgt_fec};
            end
            if (st == S_RDY && ready_ok) begin
                done_q   <= 1'b1;
                cur_cfg  <= tgt_q;
                cur_prof <= tgt_prof_q;
            end
        end
    end

    assign tx_rst = st inside {S_RST_ACK, S_DIS, S_EN, S_GO, S_GW0, S_GW1, S_GW2, S_POLL, S_ERR};
    assign rx_rst = tx_rst;
    assign busy   = !(st inside {S_IDLE, S_ERR});
    assign err    = (st == S_ERR);
    assign done   = done_q;

    lrs_wait_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (tmr_run),
        .limit  (wait_limit),
        .expire (tmr_expire)
    );

    lrs_mm_master u_master (
        .clk      (clk),
        .rst      (rst),
        .cmd_go   (cmd_go),
        .cmd_in   (cmd),
        .idle     (mst_idle),
        .cmd_done (cmd_done),
        .rd_data  (rd_data),
        .m_valid  (m_valid),
        .m_write  (m_write),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata),
        .m_ready  (m_ready),
        .m_rvalid (m_rvalid),
        .m_rdata  (m_rdata)
    );

    assert_start_resets_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (tx_rst && rx_rst && !done && !err));

    assert_poll_under_reset_R6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_write) |-> (tx_rst && rx_rst));

    assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(tx_ready && rx_ready) && !tx_rst && !rx_rst && !busy));

    assert_err_holds_reset_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (tx_rst && rx_rst && !busy));

    assert_busy_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!done && !err));

endmodule

// File: tb/lane_reconf_seq_bench.sv
module lane_reconf_seq_bench;
    import lrs_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1, start_req = 1'b0;
    logic [3:0]  tgt_profile = '0, tgt_rate = 4'd1;
    logic [4:0]  tgt_groups = 5'd1, tgt_lanes = 5'd1;
    logic [1:0]  tgt_fec = '0;
    logic [15:0] wait_limit = 16'd200;
    logic        tx_rst, rx_rst, m_valid, m_write, busy, done, err;
    logic        tx_rst_ack = 1'b0, rx_rst_ack = 1'b0, tx_ready = 1'b0, rx_ready = 1'b0;
    logic        m_ready = 1'b0, m_rvalid = 1'b0;
    logic [19:0] m_addr;
    logic [31:0] m_wdata, m_rdata = '0;

    lane_reconf_seq u_lane_reconf_seq (.*);

    int total = 0, bad = 0;
    int cyc = 0;
    logic [52:0] log_e [512];
    int log_cyc [512];
    int log_n = 0, rd_total = 0, rd_base = 0, base = 0, wcnt = 0;
    int bus_dly = 0, apply_after = 1, ack_dly = 1, ack_cnt = 0, rdy_dly = 2, rdy_cnt = 0;
    int ack_rise = 0, hold_viol = 0;
    bit ack_block = 0, rdy_block = 0, both_q = 0, pend_q = 0;
    logic [52:0] req_q = '0;
    int mp = 0, mg = 1, ml = 1, mr = 1, mf = 0;

    // reconfiguration engine model and handshake logger
    always @(posedge clk) begin
        cyc <= cyc + 1;
        m_ready  <= 1'b0;
        m_rvalid <= 1'b0;
        pend_q   <= m_valid && !m_ready;
        req_q    <= {m_write, m_addr, m_wdata};
        if (pend_q && !(m_valid && {m_write, m_addr, m_wdata} == req_q)) hold_viol <= hold_viol + 1;
        if (m_valid && !m_ready) begin
            if (wcnt >= bus_dly) begin m_ready <= 1'b1; wcnt <= 0; end
            else wcnt <= wcnt + 1;
        end
        if (m_valid && m_ready) begin
            log_e[log_n % 512]   <= {m_write, m_addr, m_wdata};
            log_cyc[log_n % 512] <= cyc;
            log_n <= log_n + 1;
            if (!m_write) begin
                m_rvalid <= 1'b1;
                m_rdata  <= (m_addr == 20'h0010C && (rd_total - rd_base + 1) >= apply_after) ? 32'h1 : 32'h0;
                rd_total <= rd_total + 1;
            end
        end
    end

    // lane model
    always @(posedge clk) begin
        tx_rst_ack <= tx_rst && !ack_block;
        if (rx_rst) begin if (ack_cnt < ack_dly) ack_cnt <= ack_cnt + 1; end
        else ack_cnt <= 0;
        rx_rst_ack <= rx_rst && (ack_cnt >= ack_dly) && !ack_block;
        if (tx_rst) rdy_cnt <= 0;
        else if (rdy_cnt < rdy_dly) rdy_cnt <= rdy_cnt + 1;
        tx_ready <= !tx_rst && (rdy_cnt >= rdy_dly) && !rdy_block;
        rx_ready <= !rx_rst;
        both_q   <= tx_rst_ack && rx_rst_ack;
        if (tx_rst_ack && rx_rst_ack && !both_q) ack_rise <= cyc;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [52:0] ent(input bit w, input int a, input int d);
        logic [19:0] a20 = a[19:0];
        logic [31:0] d32 = d;
        return {w, a20, d32};
    endfunction

    task automatic launch(input int prof, input int g, input int l, input int r, input int f);
        @(negedge clk);
        tgt_profile = 4'(prof); tgt_groups = 5'(g); tgt_lanes = 5'(l);
        tgt_rate = 4'(r); tgt_fec = 2'(f);
        start_req = 1'b1; base = log_n; rd_base = rd_total;
        @(negedge clk);
        start_req = 1'b0;
        chk(busy && tx_rst && rx_rst && !done && !err, "R1", {busy, tx_rst, rx_rst, done, err}, 5'b11100);
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 4000 && busy; n++) @(negedge clk);
    endtask

    task automatic do_run(input int prof, input int g, input int l, input int r, input int f, input bit intrude);
        logic [52:0] ex [16];
        int ne = 0;
        bit chg = (g != mg) || (l != ml) || (r != mr) || (f != mf);
        launch(prof, g, l, r, f);
        if (intrude) begin
            @(negedge clk);
            tgt_profile = ~tgt_profile; tgt_groups = 5'd7; tgt_lanes = 5'd3; tgt_rate = 4'd9; tgt_fec = 2'd1;
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        wait_idle();
        chk(done && !err && !tx_rst && !rx_rst && tx_ready && rx_ready, "R7",
            {done, err, tx_rst, rx_rst}, 4'b1000);
        ex[ne] = ent(1, 'h100, mp); ne++;
        ex[ne] = ent(1, 'h104, prof); ne++;
        ex[ne] = ent(1, 'h108, 1); ne++;
        if (chg) begin
            ex[ne] = ent(1, 'h820, g * 512 + l * 16 + r); ne++;
            ex[ne] = ent(1, 'h824, f); ne++;
            ex[ne] = ent(1, 'h828, r); ne++;
        end
        for (int k = 0; k < apply_after; k++) begin ex[ne] = ent(0, 'h10C, 0); ne++; end
        chk(log_n - base == ne, chg ? "R4 write count" : "R4 skip count", log_n - base, ne);
        for (int i = 0; i < ne && i < log_n - base; i++) begin
            if (i < 3)
                chk(log_e[(base + i) % 512] == ex[i], intrude ? "R9 target kept" : "R3", log_e[(base + i) % 512], ex[i]);
            else if (chg && i < 6)
                chk(log_e[(base + i) % 512] == ex[i], "R5", log_e[(base + i) % 512], ex[i]);
            else
                chk(log_e[(base + i) % 512] == ex[i], "R6", log_e[(base + i) % 512], ex[i]);
        end
        chk(log_cyc[base % 512] > ack_rise, "R2", log_cyc[base % 512], ack_rise);
        mp = prof; mg = g; ml = l; mr = r; mf = f;
        repeat (3) @(negedge clk);
    endtask

    task automatic main_seq();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_rst && !rx_rst && !busy && !done && !err && !m_valid, "R11",
            {tx_rst, rx_rst, busy, done, err, m_valid}, 0);
        // sweep of grouping fields with varied latencies
        for (int idx = 0; idx < 16; idx++) begin
            bus_dly = idx % 3; apply_after = 1 + idx % 3; ack_dly = idx % 4;
            do_run((idx + 1) % 16, (idx & 1) ? 3 : 1, (idx & 2) ? 2 : 1,
                   (idx & 4) ? 2 : 1, (idx & 8) ? 2 : 0, 1'b0);
        end
        // same grouping again: grouping step skipped
        do_run(5, 3, 2, 2, 2, 1'b0);
        // start while busy is ignored
        do_run(9, 1, 1, 1, 2, 1'b1);
        // reset acknowledge timeout, exact cycle
        wait_limit = 16'd20; ack_block = 1;
        launch(3, 2, 2, 1, 0);
        repeat (19) @(negedge clk);
        chk(!err && busy, "R8 not early", err, 0);
        @(negedge clk);
        chk(err && !busy && tx_rst && rx_rst, "R8 expiry", {err, busy, tx_rst, rx_rst}, 4'b1011);
        repeat (10) @(negedge clk);
        chk(err && tx_rst && rx_rst && log_n == base, "R8 held", {err, tx_rst, log_n - base}, 0);
        ack_block = 0; wait_limit = 16'd200;
        do_run(3, 2, 2, 1, 0, 1'b0);
        // applied bit never set
        wait_limit = 16'd60; apply_after = 1000;
        launch(4, 1, 2, 2, 2);
        wait_idle();
        chk(err && !done && tx_rst && rx_rst, "R8 poll", {err, done, tx_rst}, 3'b101);
        repeat (10) @(negedge clk);
        apply_after = 2;
        // lane never ready
        rdy_block = 1;
        launch(6, 1, 2, 2, 2);
        wait_idle();
        chk(err && !done && tx_rst && rx_rst, "R8 ready", {err, done, tx_rst}, 3'b101);
        rdy_block = 0; wait_limit = 16'd200;
        do_run(6, 1, 2, 2, 2, 1'b0);
        chk(hold_viol == 0, "R10", hold_viol, 0);
    endtask

    initial begin
        bit wd = 0;
        fork
            main_seq();
            begin repeat (150000) @(posedge clk); wd = 1; end
        join_any
        if (wd) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule